// File: doc/BRIEF.md
# Dual 32-bit Timer/Counter

This block holds two independent 32-bit timer/counters behind one small word-addressed register interface. Each timer has three registers: a control/status word, a load value and a live counter value. Software picks the counting direction, copies the load value into the counter with a load strobe bit, and starts or stops the timer. It also chooses whether an expiry reloads the counter for periodic operation or ends a single shot. An expiry raises a sticky flag. Software clears the flag by writing 1 to it, so writing back the control word it just read acknowledges the event. Each flag, gated by that timer's interrupt enable, drives one shared interrupt line.

Each timer is run by a four-state machine. STOP holds the count. LOAD forces the counter to the load value every cycle. RUN counts one step per cycle. DONE holds the count after a one-shot expiry. The transitions are checked in this order. Any state goes to LOAD while the load bit is set. Otherwise it goes to RUN while the enable bit is set. RUN falls to DONE on a one-shot expiry and to STOP when software clears the enable bit. LOAD falls to STOP once the load bit is cleared with the enable bit clear. DONE and STOP stay where they are until the load bit or the enable bit is set. A start-all bit, written to either control word, sets the enable bit of both timers at the same clock edge.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is 0.
- R2: Registers are decoded from the byte address. Timer 0 has control at 0x00, load at 0x04 and counter at 0x08. Timer 1 has the same three at 0x10, 0x14 and 0x18. Writes to a counter address have no effect, and reads of any other address return 0.
- R3: While control bit 5 (load) is set, the counter is forced to the load register value. Counting resumes on the clock edge after a write clears bit 5.
- R4: When running, the counter decrements by 1 per cycle if control bit 1 (down) is set and increments by 1 per cycle if it is clear.
- R5: Expiry happens on the running cycle in which the count is 0 when counting down, or all ones when counting up. Expiry sets control bit 8 (flag) on that clock edge.
- R6: With control bit 4 (reload) set, expiry copies the load value into the counter and the timer keeps running. A down count from load value N therefore expires every N+1 cycles.
- R7: With bit 4 clear, expiry holds the counter at its terminal value and clears control bit 7 (enable).
- R8: Writing 1 to bit 8 clears the flag and writing 0 leaves it unchanged. Writing back the control value just read therefore acknowledges the event.
- R9: Clearing bit 7 stops the counter, and the count stays unchanged while the timer is stopped.
- R10: `irq_out` is high exactly when some timer has both its flag (bit 8) and its interrupt enable (control bit 6) set.
- R11: Writing 1 to control bit 10 of either timer sets bit 7 of both timers on the same edge, so both start counting together. Bit 10 always reads 0.
- R12: Control bits 0, 2, 3 and 9 are stored and read back, and they have no effect on counting or on the interrupt.
- R13: A running up-counter passes from all ones to the reloaded value. With a load value of 0 this is a wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Shared interrupt request |

## Verification
The hardest situation to reach from the ports is an up-counter wrapping past all ones: counting up from reset would take 2^32 cycles. The stimulus loads 0xFFFFFFFE into the counter, stops the timer, then rewrites the load register to 0 before starting it with reload. The wrap then happens two cycles later, and the reload lands on 0. The one-shot expiry edge is also timed exactly. The bench counts edges from the write that starts the timer and checks that the flag is still clear one cycle before expiry and set on the expiry cycle itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word bit positions; software depends on these.
    localparam int CTL_MODE   = 0;
    localparam int CTL_DOWN   = 1;
    localparam int CTL_GEN    = 2;
    localparam int CTL_CAP    = 3;
    localparam int CTL_RELOAD = 4;
    localparam int CTL_LOAD   = 5;
    localparam int CTL_IE     = 6;
    localparam int CTL_RUN    = 7;
    localparam int CTL_FLAG   = 8;
    localparam int CTL_PWM    = 9;
    localparam int CTL_ALL    = 10;

    localparam int CTL_STORED = 10;   // bits 0..9 are held in a register

    // Packed so that mode lands on bit 0 and pwm on bit 9.
    typedef struct packed {
        logic pwm;
        logic flag;
        logic run;
        logic ie;
        logic load;
        logic reload;
        logic cap;
        logic gen;
        logic down;
        logic mode;
    } tmr_ctl_t;

    typedef enum logic [1:0] {
        REG_CTL   = 2'd0,
        REG_LOAD  = 2'd1,
        REG_COUNT = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } tmr_state_e;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_load,
    input  logic              start_all,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] load_rd,
    output logic [DATA_W-1:0] cnt_rd,
    output logic              flag_o,
    output logic              ie_o
);

    localparam logic [DATA_W-1:0] CNT_ZERO = '0;
    localparam logic [DATA_W-1:0] CNT_TOP  = '1;

    tmr_state_e        state_q, state_d;
    tmr_ctl_t          ctl_q, ctl_d;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q, cnt_d;
    logic              at_term;
    logic              expire;

    assign at_term = ctl_q.down ? (cnt_q == CNT_ZERO) : (cnt_q == CNT_TOP);
    assign expire  = (state_q == ST_RUN) && at_term;

    // Next control word: expiry first, then software write, then start-all.
    always_comb begin
        ctl_d = ctl_q;
        if (expire) begin
            ctl_d.flag = 1'b1;
            if (!ctl_q.reload) begin
                ctl_d.run = 1'b0;
            end
        end
        if (wr_ctl) begin
            ctl_d.mode   = wdata[CTL_MODE];
            ctl_d.down   = wdata[CTL_DOWN];
            ctl_d.gen    = wdata[CTL_GEN];
            ctl_d.cap    = wdata[CTL_CAP];
            ctl_d.reload = wdata[CTL_RELOAD];
            ctl_d.load   = wdata[CTL_LOAD];
            ctl_d.ie     = wdata[CTL_IE];
            ctl_d.run    = wdata[CTL_RUN];
            ctl_d.pwm    = wdata[CTL_PWM];
            if (wdata[CTL_FLAG] && !expire) begin
                ctl_d.flag = 1'b0;
            end
        end
        if (start_all) begin
            ctl_d.run = 1'b1;
        end
    end

    // Next state, taken from the next control word.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (ctl_d.load)      state_d = ST_LOAD;
                else if (ctl_d.run)  state_d = ST_RUN;
                else                 state_d = ST_STOP;
            end
            ST_LOAD: begin
                if (ctl_d.load)      state_d = ST_LOAD;
                else if (ctl_d.run)  state_d = ST_RUN;
                else                 state_d = ST_STOP;
            end
            ST_RUN: begin
                if (ctl_d.load)      state_d = ST_LOAD;
                else if (ctl_d.run)  state_d = ST_RUN;
                else if (expire)     state_d = ST_DONE;
                else                 state_d = ST_STOP;
            end
            ST_DONE: begin
                if (ctl_d.load)      state_d = ST_LOAD;
                else if (ctl_d.run)  state_d = ST_RUN;
                else                 state_d = ST_DONE;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // Counter datapath, driven by the registered state.
    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            ST_LOAD: cnt_d = load_q;
            ST_RUN: begin
                if (at_term) begin
                    cnt_d = ctl_q.reload ? load_q : cnt_q;
                end else if (ctl_q.down) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            load_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
            if (wr_load) begin
                load_q <= wdata;
            end
        end
    end

    // Outputs; bit 10 (start-all) is a strobe and reads back as 0.
    always_comb begin
        ctl_rd  = {{(DATA_W - CTL_STORED){1'b0}}, ctl_q};
        load_rd = load_q;
        cnt_rd  = cnt_q;
        flag_o  = ctl_q.flag;
        ie_o    = ctl_q.ie;
    end

    AST_LOAD_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (cnt_q == $past(load_q)));  // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctl_q.down && !at_term) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R4

    AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctl_q.flag);  // R5

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctl_q.reload) |=> (cnt_q == $past(load_q)));  // R6

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctl_q.reload && !wr_ctl && !start_all) |=> (!ctl_q.run && $stable(cnt_q)));  // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP || state_q == ST_DONE) |=> $stable(cnt_q));  // R9

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM    = 2,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      all_req,
    input  logic [NUM-1:0][DATA_W-1:0] ctl_rd_all,
    input  logic [NUM-1:0][DATA_W-1:0] load_rd_all,
    input  logic [NUM-1:0][DATA_W-1:0] cnt_rd_all,
    output logic [NUM-1:0]            wr_ctl,
    output logic [NUM-1:0]            wr_load,
    output logic                      start_all,
    output logic [DATA_W-1:0]         bus_rdata
);

    localparam int IDX_LSB = 4;
    localparam int IDX_W   = ADDR_W - IDX_LSB;

    logic [IDX_W-1:0] slot;
    reg_sel_e         sel;
    logic             hit;
    logic             wr_en;

    assign slot  = bus_addr[IDX_LSB +: IDX_W];
    assign sel   = reg_sel_e'(bus_addr[3:2]);
    assign hit   = (int'(slot) < NUM) && (bus_addr[1:0] == 2'b00);
    assign wr_en = bus_sel && bus_wr && hit;

    for (genvar g = 0; g < NUM; g++) begin : g_strobe
        localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(g);
        assign wr_ctl[g]  = wr_en && (slot == SLOT_ID) && (sel == REG_CTL);
        assign wr_load[g] = wr_en && (slot == SLOT_ID) && (sel == REG_LOAD);
    end

    assign start_all = (|wr_ctl) && all_req;

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                REG_CTL:   bus_rdata = ctl_rd_all[slot];
                REG_LOAD:  bus_rdata = load_rd_all[slot];
                REG_COUNT: bus_rdata = cnt_rd_all[slot];
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctl, wr_load}));  // R2

endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
    parameter int NUM = 2
) (
    input  logic [NUM-1:0] flags,
    input  logic [NUM-1:0] enables,
    output logic           irq
);

    assign irq = |(flags & enables);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter  int NUM_TIMERS = 2,
    parameter  int DATA_W     = 32,
    localparam int ADDR_W     = 4 + $clog2(NUM_TIMERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [NUM_TIMERS-1:0][DATA_W-1:0] ctl_rd_all;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] load_rd_all;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_rd_all;
    logic [NUM_TIMERS-1:0]             wr_ctl;
    logic [NUM_TIMERS-1:0]             wr_load;
    logic [NUM_TIMERS-1:0]             flag_vec;
    logic [NUM_TIMERS-1:0]             ie_vec;
    logic                              start_all;

    tmr_decode #(
        .DATA_W (DATA_W),
        .NUM    (NUM_TIMERS),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .all_req     (bus_wdata[CTL_ALL]),
        .ctl_rd_all  (ctl_rd_all),
        .load_rd_all (load_rd_all),
        .cnt_rd_all  (cnt_rd_all),
        .wr_ctl      (wr_ctl),
        .wr_load     (wr_load),
        .start_all   (start_all),
        .bus_rdata   (bus_rdata)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        tmr_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (wr_ctl[t]),
            .wr_load   (wr_load[t]),
            .start_all (start_all),
            .wdata     (bus_wdata),
            .ctl_rd    (ctl_rd_all[t]),
            .load_rd   (load_rd_all[t]),
            .cnt_rd    (cnt_rd_all[t]),
            .flag_o    (flag_vec[t]),
            .ie_o      (ie_vec[t])
        );
    end

    tmr_irq_merge #(
        .NUM (NUM_TIMERS)
    ) u_irq (
        .flags   (flag_vec),
        .enables (ie_vec),
        .irq     (irq_out)
    );

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|flag_vec));  // R10

    AST_ALL_STARTS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        start_all |=> (ctl_rd_all[0][CTL_RUN] && ctl_rd_all[NUM_TIMERS-1][CTL_RUN]));  // R11

endmodule

// File: tb/tmr_pair_test.sv
module tmr_pair_test;

    localparam logic [31:0] B_DOWN   = 32'h0000_0002;
    localparam logic [31:0] B_RELOAD = 32'h0000_0010;
    localparam logic [31:0] B_LOAD   = 32'h0000_0020;
    localparam logic [31:0] B_IE     = 32'h0000_0040;
    localparam logic [31:0] B_RUN    = 32'h0000_0080;
    localparam logic [31:0] B_FLAG   = 32'h0000_0100;
    localparam logic [31:0] B_ALL    = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_pair uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_sel = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        foreach (v[i]) begin end
        rd(5'h00, v); chk("R1 ctl0", v, 0);
        rd(5'h04, v); chk("R1 load0", v, 0);
        rd(5'h08, v); chk("R1 cnt0", v, 0);
        rd(5'h10, v); chk("R1 ctl1", v, 0);
        rd(5'h14, v); chk("R1 load1", v, 0);
        rd(5'h18, v); chk("R1 cnt1", v, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(5'h14, 32'hA5A5_0001);
        rd(5'h14, v); chk("R2 load1 readback", v, 32'hA5A5_0001);
        rd(5'h04, v); chk("R2 load0 untouched", v, 0);
        wr(5'h18, 32'h0000_1234);
        idle(1);
        rd(5'h18, v); chk("R2 counter write ignored", v, 0);
        rd(5'h0C, v); chk("R2 unmapped reads 0", v, 0);
    endtask

    task automatic t_load_hold();
        logic [31:0] v;
        do_reset();
        wr(5'h04, 32'd100);
        wr(5'h00, B_LOAD | B_RUN | B_DOWN);
        idle(3);
        rd(5'h08, v); chk("R3 held at load value", v, 32'd100);
        wr(5'h00, B_RUN | B_DOWN);
        rd(5'h08, v); chk("R3 still load value on release edge", v, 32'd100);
        idle(2);
        rd(5'h08, v); chk("R3 counting after release", v, 32'd98);
    endtask

    task automatic t_up();
        logic [31:0] v;
        do_reset();
        wr(5'h14, 32'd10);
        wr(5'h10, B_LOAD);
        wr(5'h10, B_RUN);
        rd(5'h18, v); chk("R4 up start", v, 32'd10);
        idle(3);
        rd(5'h18, v); chk("R4 up counts", v, 32'd13);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(5'h04, 32'd5);
        wr(5'h00, B_LOAD);
        wr(5'h00, B_RUN | B_DOWN);
        idle(5);
        rd(5'h08, v); chk("R5 reached zero", v, 0);
        rd(5'h00, v); chk("R5 no flag before expiry", v & B_FLAG, 0);
        idle(1);
        rd(5'h00, v); chk("R7 one-shot clears enable, sets flag", v, B_DOWN | B_FLAG);
        idle(3);
        rd(5'h08, v); chk("R7 count held after expiry", v, 0);
    endtask

    task automatic t_reload_ack();
        logic [31:0] v;
        do_reset();
        wr(5'h04, 32'd3);
        wr(5'h00, B_LOAD);
        wr(5'h00, B_RUN | B_DOWN | B_RELOAD | B_IE);
        idle(4);
        rd(5'h08, v); chk("R6 reloaded on expiry", v, 32'd3);
        rd(5'h00, v); chk("R6 flag and enable set", v & (B_FLAG | B_RUN), B_FLAG | B_RUN);
        chk("R10 irq with flag and enable", {31'b0, irq_out}, 1);
        idle(4);
        rd(5'h08, v); chk("R6 period of N+1", v, 32'd3);
        wr(5'h00, B_DOWN | B_RELOAD | B_IE);
        idle(1);
        rd(5'h00, v); chk("R8 writing 0 keeps flag", v, B_DOWN | B_RELOAD | B_IE | B_FLAG);
        chk("R10 irq still high", {31'b0, irq_out}, 1);
        wr(5'h00, v);
        rd(5'h00, v); chk("R8 write-back acknowledges", v, B_DOWN | B_RELOAD | B_IE);
        chk("R10 irq drops after ack", {31'b0, irq_out}, 0);
    endtask

    task automatic t_ie_gate();
        logic [31:0] v;
        do_reset();
        wr(5'h14, 32'hFFFF_FFFE);
        wr(5'h10, B_LOAD);
        wr(5'h10, B_RUN);
        idle(1);
        rd(5'h18, v); chk("R5 up reaches all ones", v, 32'hFFFF_FFFF);
        idle(1);
        rd(5'h10, v); chk("R5 up expiry flag, R7 enable cleared", v, B_FLAG);
        rd(5'h18, v); chk("R7 up count held", v, 32'hFFFF_FFFF);
        chk("R10 irq gated by enable", {31'b0, irq_out}, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        wr(5'h14, 32'hFFFF_FFFE);
        wr(5'h10, B_LOAD);
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h0);
        wr(5'h10, B_RUN | B_RELOAD);
        rd(5'h18, v); chk("R13 start near top", v, 32'hFFFF_FFFE);
        idle(1);
        rd(5'h18, v); chk("R13 all ones", v, 32'hFFFF_FFFF);
        idle(1);
        rd(5'h18, v); chk("R13 wrapped to 0", v, 0);
        idle(1);
        rd(5'h18, v); chk("R13 keeps running", v, 32'd1);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        logic [31:0] c;
        do_reset();
        wr(5'h04, 32'd1000);
        wr(5'h00, B_LOAD);
        wr(5'h00, B_RUN | B_DOWN);
        idle(5);
        wr(5'h00, B_DOWN);
        rd(5'h08, c); chk("R9 stopped value", c, 32'd994);
        idle(6);
        rd(5'h08, v); chk("R9 value held", v, c);
    endtask

    task automatic t_start_all();
        logic [31:0] v;
        do_reset();
        wr(5'h04, 32'd50);
        wr(5'h14, 32'd60);
        wr(5'h00, B_LOAD | B_DOWN);
        wr(5'h10, B_LOAD);
        wr(5'h00, B_DOWN);
        wr(5'h10, 32'h0);
        wr(5'h10, B_ALL);
        rd(5'h00, v); chk("R11 timer0 enabled", v, B_DOWN | B_RUN);
        rd(5'h10, v); chk("R11 timer1 enabled, bit10 reads 0", v, B_RUN);
        idle(2);
        rd(5'h08, v); chk("R11 timer0 counted", v, 32'd48);
        rd(5'h18, v); chk("R11 timer1 counted", v, 32'd62);
    endtask

    task automatic t_held_bits();
        logic [31:0] v;
        do_reset();
        wr(5'h04, 32'd7);
        wr(5'h00, B_LOAD);
        wr(5'h00, 32'h0000_020D);
        rd(5'h00, v); chk("R12 held bits read back", v, 32'h0000_020D);
        idle(3);
        rd(5'h08, v); chk("R12 no counting effect", v, 32'd7);
        chk("R12 no irq effect", {31'b0, irq_out}, 0);
    endtask

    initial begin
        t_reset();
        t_map();
        t_load_hold();
        t_up();
        t_oneshot();
        t_reload_ack();
        t_ie_gate();
        t_wrap();
        t_stop();
        t_start_all();
        t_held_bits();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule